// File: doc/BRIEF.md
# Chained Indirect Effective-Address Resolver

This block finds the effective address of a memory-reference instruction on a 16-bit, word-addressed memory. It takes a 16-bit operand word. The top bit of that word is an indirect marker and the lower fifteen bits are an address. When the marker is clear, the address is final. When it is set, the block reads the word at that address and tests it in the same way. It keeps following pointers until it reaches a word whose marker is clear. Because one bit of each word is the marker, only a 32K-word space can be reached.

The instruction sequencer starts a resolution with a one-cycle start pulse and receives a one-cycle done pulse. The done pulse carries the final address, the number of pointer reads taken and an error flag. Toward memory the block has a plain synchronous read port: an enable, an address, and a returned word qualified by a valid strobe. A parameter sets a hop limit. When the limit is reached the chain is cut off and flagged, so a circular pointer chain cannot hang the sequencer.

Top module: `ind_addr_resolver`

## Requirements
- R1: After synchronous reset, resolveDone, chainError and memRdEn are 0, and hopCount and effAddr are 0.
- R2: A start whose word has bit 15 clear produces resolveDone on the cycle after the start edge. It reports effAddr equal to bits 14:0 of the word, hopCount 0 and chainError 0, and it issues no memory read.
- R3: A start whose word has bit 15 set raises memRdEn for one cycle on the cycle after the start edge, with memRdAddr equal to bits 14:0 of the word. Bit 15 never reaches any address output.
- R4: Each returned word is tested on bit 15 again. When bit 15 is set, the next read goes to the returned word's bits 14:0.
- R5: The chain ends at the first returned word with bit 15 clear. effAddr is that word's bits 14:0, hopCount is the number of reads made, and chainError is 0. With one-cycle memory latency, done appears 2n+1 cycles after the start edge for n reads.
- R6: The block issues at most one read per step and issues the next one only after memRdValid has returned the previous word.
- R7: If a returned word has bit 15 set after HOP_LIMIT reads (default 64), no further read is made. Done is raised with chainError 1, hopCount equal to HOP_LIMIT, and effAddr equal to bits 14:0 of that still-flagged word. A chain that ends after exactly HOP_LIMIT reads completes without error.
- R8: resolveDone is a single-cycle pulse per resolution, and chainError is high only together with resolveDone.
- R9: A start pulse that arrives while a resolution is in progress is ignored. The running chain, its result and the number of done pulses are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | One-cycle request to resolve instrWord |
| instrWord | input | 16 | Operand word: bit 15 indirect marker, bits 14:0 address |
| memRdEn | output | 1 | Read request toward memory |
| memRdAddr | output | 15 | Read address |
| memRdValid | input | 1 | Returned word is valid |
| memRdData | input | 16 | Returned word |
| resolveDone | output | 1 | One-cycle completion pulse |
| effAddr | output | 15 | Resolved effective address |
| hopCount | output | 7 | Number of pointer reads made |
| chainError | output | 1 | Hop limit reached, chain aborted |

## Verification
A direct start, with the marker clear, must show done on the first sampled cycle after the start edge. A chained start must show its first read request on that same first cycle. Each hop costs two cycles: one for the read request register and one for the memory response. A chain of n reads, whether it ends normally or is aborted at the limit, therefore finishes on exactly cycle 2n+1. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start pulse and compares that count, along with the address, hop count and error flag, against a bench model that walks the same memory contents.

// File: rtl/ind_addr_resolver_pkg.sv
package ind_addr_resolver_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} resState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selRd;   // 1: act on returned word, 0: act on instruction word
    logic issue;   // launch a pointer read at the selected word's address
    logic finish;  // selected word is final, report it
    logic abort;   // hop limit reached, report with error
  } resCtl_t;
endpackage

// File: rtl/ind_addr_ctrl.sv
module ind_addr_ctrl
  import ind_addr_resolver_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    startReq,
  input  logic    startFlag,
  input  logic    rdValid,
  input  logic    rdFlag,
  input  logic    hopAtLimit,
  output resCtl_t ctl,
  output logic    busy
);
  resState_e state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctl.selRd = 1'b0;
          if (!startFlag) begin
            ctl.finish = 1'b1;
          end else begin
            ctl.issue = 1'b1;
            nextState = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (rdValid) begin
          ctl.selRd = 1'b1;
          if (!rdFlag) begin
            ctl.finish = 1'b1;
            nextState  = ST_IDLE;
          end else if (hopAtLimit) begin
            ctl.abort = 1'b1;
            nextState = ST_IDLE;
          end else begin
            ctl.issue = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  assign busy = (state == ST_WAIT);

  // R8: one outcome per step at most
  a_r8_single_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.issue, ctl.finish, ctl.abort}));

  // R6: while waiting without a response, nothing is launched and the wait continues
  a_r6_wait_for_valid: assert property (@(posedge clk) disable iff (rst)
    (busy && !rdValid) |=> busy);
endmodule

// File: rtl/ind_addr_datapath.sv
module ind_addr_datapath
  import ind_addr_resolver_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int HOP_LIMIT = 64,
  localparam int ADDR_W   = WORD_W - 1,
  localparam int HOP_W    = $clog2(HOP_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  resCtl_t           ctl,
  input  logic [WORD_W-1:0] instrWord,
  input  logic [WORD_W-1:0] rdData,
  output logic              hopAtLimit,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              resolveDone,
  output logic [ADDR_W-1:0] effAddr,
  output logic [HOP_W-1:0]  hopCount,
  output logic              chainError
);
  localparam logic [HOP_W-1:0] HOP_MAX = HOP_W'(HOP_LIMIT);

  logic [WORD_W-1:0] srcWord;
  logic [HOP_W-1:0]  hopBase;
  logic [HOP_W-1:0]  hopReg;

  assign srcWord    = ctl.selRd ? rdData : instrWord;
  assign hopBase    = ctl.selRd ? hopReg : '0;
  assign hopAtLimit = (hopReg == HOP_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      memRdEn     <= 1'b0;
      memRdAddr   <= '0;
      resolveDone <= 1'b0;
      chainError  <= 1'b0;
      effAddr     <= '0;
      hopReg      <= '0;
    end else begin
      memRdEn     <= ctl.issue;
      resolveDone <= ctl.finish | ctl.abort;
      chainError  <= ctl.abort;
      if (ctl.issue) begin
        memRdAddr <= srcWord[ADDR_W-1:0];
        hopReg    <= hopBase + HOP_W'(1);
      end
      if (ctl.finish || ctl.abort) begin
        effAddr <= srcWord[ADDR_W-1:0];
        hopReg  <= hopBase;
      end
    end
  end

  assign hopCount = hopReg;

  // R7: error only at the limit and only with done
  a_r7_error_at_limit: assert property (@(posedge clk) disable iff (rst)
    chainError |-> (resolveDone && hopCount == HOP_MAX));

  // R7: hop count never passes the limit
  a_r7_hop_bound: assert property (@(posedge clk) disable iff (rst)
    hopCount <= HOP_MAX);

  // R6: a read request lasts one cycle; the next waits for the response
  a_r6_one_read_per_step: assert property (@(posedge clk) disable iff (rst)
    memRdEn |=> !memRdEn);
endmodule

// File: rtl/ind_addr_resolver.sv
module ind_addr_resolver
  import ind_addr_resolver_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int HOP_LIMIT = 64,
  localparam int ADDR_W   = WORD_W - 1,
  localparam int HOP_W    = $clog2(HOP_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic [WORD_W-1:0] instrWord,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdValid,
  input  logic [WORD_W-1:0] memRdData,
  output logic              resolveDone,
  output logic [ADDR_W-1:0] effAddr,
  output logic [HOP_W-1:0]  hopCount,
  output logic              chainError
);
  resCtl_t ctl;
  logic    hopAtLimit;
  logic    busy;

  ind_addr_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .startReq   (startReq),
    .startFlag  (instrWord[WORD_W-1]),
    .rdValid    (memRdValid),
    .rdFlag     (memRdData[WORD_W-1]),
    .hopAtLimit (hopAtLimit),
    .ctl        (ctl),
    .busy       (busy)
  );

  ind_addr_datapath #(.WORD_W(WORD_W), .HOP_LIMIT(HOP_LIMIT)) dp_i (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .instrWord   (instrWord),
    .rdData      (memRdData),
    .hopAtLimit  (hopAtLimit),
    .memRdEn     (memRdEn),
    .memRdAddr   (memRdAddr),
    .resolveDone (resolveDone),
    .effAddr     (effAddr),
    .hopCount    (hopCount),
    .chainError  (chainError)
  );

  // R2: direct word completes next cycle with its own address field
  a_r2_direct_finish: assert property (@(posedge clk) disable iff (rst)
    (!busy && startReq && !instrWord[WORD_W-1]) |=>
      (resolveDone && !chainError && hopCount == '0 &&
       effAddr == $past(instrWord[ADDR_W-1:0]) && !memRdEn));

  // R3: flagged word launches a read at its address field next cycle
  a_r3_first_read: assert property (@(posedge clk) disable iff (rst)
    (!busy && startReq && instrWord[WORD_W-1]) |=>
      (memRdEn && memRdAddr == $past(instrWord[ADDR_W-1:0])));

  // R4: a flagged response within the limit chains to its own address
  a_r4_rechain: assert property (@(posedge clk) disable iff (rst)
    (busy && memRdValid && memRdData[WORD_W-1] && !hopAtLimit) |=>
      (memRdEn && memRdAddr == $past(memRdData[ADDR_W-1:0])));

  // R9: a start during a chain does not end it
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && startReq && !memRdValid) |=> !resolveDone);
endmodule

// File: tb/ind_addr_resolver_tb_top.sv
module ind_addr_resolver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 64;
  localparam int HW         = $clog2(LIMIT + 1);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startReq = 1'b0;
  logic [15:0] instrWord = '0;
  logic        memRdEn;
  logic [14:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [15:0] memRdData = '0;
  logic        resolveDone;
  logic [14:0] effAddr;
  logic [HW-1:0] hopCount;
  logic        chainError;

  logic [15:0] mem [256];
  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ind_addr_resolver #(.WORD_W(16), .HOP_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst(rst), .startReq(startReq), .instrWord(instrWord),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .resolveDone(resolveDone), .effAddr(effAddr),
    .hopCount(hopCount), .chainError(chainError)
  );

  // memory with one-cycle read latency; index uses the low 8 address bits
  always @(posedge clk) begin
    memRdValid <= memRdEn && !rst;
    memRdData  <= mem[memRdAddr[7:0]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] w, output int addr,
                                output int hops, output bit err);
    logic [15:0] cur = w;
    hops = 0;
    err  = 1'b0;
    while (cur[15]) begin
      if (hops == LIMIT) begin
        err = 1'b1;
        break;
      end
      cur = mem[cur[7:0]];
      hops++;
    end
    addr = int'(cur[14:0]);
  endfunction

  // starts one resolution after a falling edge and checks the result
  task automatic runOne(input logic [15:0] w, input string req);
    int  expAddr, expHops, cycles;
    bit  expErr;
    model(w, expAddr, expHops, expErr);
    instrWord = w;
    startReq  = 1'b1;
    @(negedge clk);
    startReq  = 1'b0;
    cycles    = 1;
    if (w[15])
      chk(memRdEn && memRdAddr == w[14:0], "R3", "first read addr",
          memRdEn ? memRdAddr : -1, w[14:0]);
    while (!resolveDone && cycles < 400) begin
      @(negedge clk);
      cycles++;
    end
    chk(resolveDone, req, "done seen", resolveDone, 1);
    chk(cycles == 2*expHops + 1, "R5", "done cycle", cycles, 2*expHops + 1);
    chk(effAddr == expAddr[14:0], req, "effAddr", effAddr, expAddr);
    chk(hopCount == HW'(expHops), req, "hopCount", hopCount, expHops);
    chk(chainError == expErr, expErr ? "R7" : req, "chainError", chainError, expErr);
    @(negedge clk);
    chk(!resolveDone && !chainError, "R8", "done pulse width", resolveDone, 0);
  endtask

  // global watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!resolveDone && !chainError && !memRdEn, "R1", "outputs idle", resolveDone, 0);
    chk(hopCount == '0 && effAddr == '0, "R1", "hop and addr zero", hopCount, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2: direct, including all-ones address field
    runOne(16'h7ABC, "R2");
    runOne(16'h0000, "R2");
    runOne(16'h7FFF, "R2");

    // R3/R4/R5: single hop, top bit excluded from address
    mem[8'hFF] = 16'h1234;
    runOne(16'hFFFF, "R4");
    mem[8'h10] = 16'h8020;
    mem[8'h20] = 16'h8030;
    mem[8'h30] = 16'h0555;
    runOne(16'h8010, "R5");

    // R7: chain of exactly LIMIT reads completes
    for (int i = 1; i < LIMIT; i++) mem[i] = 16'h8000 | 16'(i + 1);
    mem[LIMIT] = 16'h0ABC;
    runOne(16'h8001, "R7");
    // R7: one more hop needed -> abort
    mem[LIMIT] = 16'h8000 | 16'(LIMIT + 1);
    mem[LIMIT + 1] = 16'h0001;
    runOne(16'h8001, "R7");
    // R7: self loop
    mem[8'hC5] = 16'h80C5;
    runOne(16'h80C5, "R7");

    // R9: start while busy is ignored
    begin
      int expAddr, expHops, cycles, dones;
      bit expErr;
      mem[8'h40] = 16'h8041;
      mem[8'h41] = 16'h8042;
      mem[8'h42] = 16'h0777;
      model(16'h8040, expAddr, expHops, expErr);
      instrWord = 16'h8040;
      startReq  = 1'b1;
      @(negedge clk);
      startReq  = 1'b0;
      @(negedge clk);
      instrWord = 16'h0123;
      startReq  = 1'b1;
      @(negedge clk);
      startReq  = 1'b0;
      cycles = 3;
      while (!resolveDone && cycles < 400) begin
        @(negedge clk);
        cycles++;
      end
      chk(cycles == 2*expHops + 1, "R9", "done cycle unchanged", cycles, 2*expHops + 1);
      chk(effAddr == expAddr[14:0], "R9", "effAddr unchanged", effAddr, expAddr);
      dones = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (resolveDone) dones++;
      end
      chk(dones == 0, "R9", "extra done pulses", dones, 0);
    end

    // random chains, three densities of flagged words
    for (int t = 0; t < 45; t++) begin
      int density = (t % 3 == 0) ? 4 : ((t % 3 == 1) ? 2 : 8);
      for (int i = 0; i < 256; i++) begin
        logic [15:0] v = 16'($urandom);
        v[15] = (($urandom % density) != 0) ? (density == 8) : (density != 8);
        if (density == 2) v[15] = $urandom % 2;
        mem[i] = v;
      end
      runOne(16'($urandom) | 16'h8000, "R4");
      runOne(16'($urandom), "R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule